// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensator

This block measures the round trip of a frame's own signal through the external transceiver and uses the result to check bits during the fast data phase. The measurement starts when the protocol engine marks the recessive-to-dominant edge it transmits between the flexible-data-format bit and the reserved bit. It ends when the same dominant edge comes back on the receive line. A programmable minimum window stops a short dominant glitch, seen while the received line should still be recessive, from ending the measurement early.

During the data phase the protocol engine flags each transmit-bit start. The block stores the transmitted value together with that start time in a delay line. It then raises a secondary sample point strobe exactly one measured delay plus a programmable offset later, and compares the stored bit with the bit currently on the receive line. Several bits can be in flight at once, because the compensated delay may be longer than one data bit. The strobes are suppressed outside the data phase, while a measurement is still running, and after a measurement that saw no returning edge.

Top module: `tx_delay_comp`

## Requirements
- R1: After reset, measDelay is 0 and measTimeout, sspStrobe and bitErr are all low.
- R2: edgeMark is high in cycle c. If rxBit is first low (0 = dominant) in a cycle c+D that satisfies D ≥ filtWin and D ≤ 2^CW−1, then measDelay reads D from cycle c+D+1 onward. This includes D = 2^CW−1.
- R3: A low rxBit in cycle c+G with G < filtWin does not end the measurement.
- R4: While a measurement is running, measDelay keeps the value from the last completed measurement.
- R5: If no qualifying low rxBit arrives by cycle c+2^CW−1, measTimeout is high from cycle c+2^CW onward and measDelay is unchanged. The next edgeMark clears measTimeout from the following cycle. While measTimeout is high, sspStrobe stays low.
- R6: bitStart is high in cycle b while dataPhase is high and the last measurement completed. Then sspStrobe is high in cycle b+measDelay+sspOffset, provided dataPhase is high in that cycle. Otherwise sspStrobe is low.
- R7: bitErr is high exactly when sspStrobe is high and rxBit differs from the txBit value present in the matching bitStart cycle.
- R8: Bit starts spaced closer than measDelay+sspOffset each produce their own strobe and comparison.
- R9: No strobe is produced for a bit start taken while dataPhase is low, nor in any cycle where dataPhase is low.
- R10: From the cycle after edgeMark until the measurement completes, sspStrobe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txBit | input | 1 | Bit currently driven to the transceiver |
| rxBit | input | 1 | Bit read back from the bus, 0 = dominant |
| dataPhase | input | 1 | High while the frame is in its data phase |
| edgeMark | input | 1 | One-cycle pulse when the transmitted edge into the reserved bit is driven; starts a measurement |
| bitStart | input | 1 | One-cycle pulse at each transmit-bit start |
| filtWin | input | CW | Minimum accepted delay, in clock cycles |
| sspOffset | input | CW | Offset added to the delay, in clock cycles |
| measDelay | output | CW | Last completed delay measurement |
| measTimeout | output | 1 | Last measurement saw no returning edge |
| sspStrobe | output | 1 | Secondary sample point pulse |
| bitErr | output | 1 | Mismatch at the secondary sample point |

## Verification
The assertions assume that edgeMark, bitStart and dataPhase come from a protocol engine. They also assume that filtWin stays constant from edgeMark until the measurement ends, because the window check looks back one cycle at filtWin. The bench loads filtWin and sspOffset only while no measurement runs. It separates data-phase runs with idle gaps longer than the delay line, so that no old bit start reaches the tap. It drives rxBit as a delayed copy of txBit, with deliberate flips and glitches.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_MEAS = 1'b1} measState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startMeas;
    logic step;
    logic capture;
    logic expire;
    logic sspEn;
  } tdcCmd_t;
endpackage

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    edgeMark,
  input  logic    rxBit,
  input  logic    dataPhase,
  input  logic    winReached,
  input  logic    atMax,
  output tdcCmd_t cmd,
  output logic    measTimeout
);
  measState_t state;
  logic measOk;

  always_comb begin
    cmd = '0;
    cmd.startMeas = edgeMark;
    if (!edgeMark && state == ST_MEAS) begin
      if (!rxBit && winReached) cmd.capture = 1'b1;
      else if (atMax)           cmd.expire  = 1'b1;
      else                      cmd.step    = 1'b1;
    end
    cmd.sspEn = measOk && dataPhase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      measOk      <= 1'b0;
      measTimeout <= 1'b0;
    end else begin
      if (cmd.startMeas) begin
        state       <= ST_MEAS;
        measOk      <= 1'b0;
        measTimeout <= 1'b0;
      end else if (cmd.capture) begin
        state  <= ST_IDLE;
        measOk <= 1'b1;
      end else if (cmd.expire) begin
        state       <= ST_IDLE;
        measOk      <= 1'b0;
        measTimeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tdcCmd_t       cmd,
  input  logic          txBit,
  input  logic          rxBit,
  input  logic          bitStart,
  input  logic          dataPhase,
  input  logic [CW-1:0] filtWin,
  input  logic [CW-1:0] sspOffset,
  output logic          winReached,
  output logic          atMax,
  output logic [CW-1:0] measDelay,
  output logic          sspStrobe,
  output logic          bitErr
);
  localparam int TW   = CW + 1;
  localparam int HLEN = 1 << TW;
  localparam logic [TW-1:0] MAXD = TW'((1 << CW) - 1);

  logic [CW-1:0]   cnt;
  logic [TW-1:0]   cntNext;
  logic [TW-1:0]   total;
  logic [TW-1:0]   tapIdx;
  logic [HLEN-1:0] histStart;
  logic [HLEN-1:0] histTx;

  assign cntNext    = {1'b0, cnt} + TW'(1);
  assign winReached = cntNext >= {1'b0, filtWin};
  assign atMax      = cntNext == MAXD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      measDelay <= '0;
    end else begin
      if (cmd.startMeas || cmd.expire) cnt <= '0;
      else if (cmd.step)               cnt <= cnt + CW'(1);
      if (cmd.capture) measDelay <= cntNext[CW-1:0];
    end
  end

  // history of bit starts and transmitted values, one slot per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      histStart <= '0;
      histTx    <= '0;
    end else begin
      histStart <= {histStart[HLEN-2:0], bitStart && dataPhase};
      histTx    <= {histTx[HLEN-2:0], txBit};
    end
  end

  // slot k holds the value from k+1 cycles ago
  assign total  = {1'b0, measDelay} + {1'b0, sspOffset};
  assign tapIdx = total - TW'(1);

  assign sspStrobe = cmd.sspEn && histStart[tapIdx];
  assign bitErr    = sspStrobe && (histTx[tapIdx] != rxBit);
endmodule

// File: rtl/tx_delay_comp.sv
module tx_delay_comp
  import tdc_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txBit,
  input  logic          rxBit,
  input  logic          dataPhase,
  input  logic          edgeMark,
  input  logic          bitStart,
  input  logic [CW-1:0] filtWin,
  input  logic [CW-1:0] sspOffset,
  output logic [CW-1:0] measDelay,
  output logic          measTimeout,
  output logic          sspStrobe,
  output logic          bitErr
);
  tdcCmd_t cmd;
  logic winReached;
  logic atMax;

  tdc_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .edgeMark   (edgeMark),
    .rxBit      (rxBit),
    .dataPhase  (dataPhase),
    .winReached (winReached),
    .atMax      (atMax),
    .cmd        (cmd),
    .measTimeout(measTimeout)
  );

  tdc_datapath #(.CW(CW)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .txBit     (txBit),
    .rxBit     (rxBit),
    .bitStart  (bitStart),
    .dataPhase (dataPhase),
    .filtWin   (filtWin),
    .sspOffset (sspOffset),
    .winReached(winReached),
    .atMax     (atMax),
    .measDelay (measDelay),
    .sspStrobe (sspStrobe),
    .bitErr    (bitErr)
  );
endmodule

// File: rtl/tx_delay_comp_chk.sv
module tx_delay_comp_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edgeMark,
  input logic          dataPhase,
  input logic [CW-1:0] filtWin,
  input logic [CW-1:0] measDelay,
  input logic          measTimeout,
  input logic          sspStrobe,
  input logic          bitErr
);
  assert_ssp_in_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sspStrobe |-> dataPhase);

  assert_err_at_ssp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bitErr |-> sspStrobe);

  assert_quiet_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edgeMark |=> !sspStrobe);

  assert_timeout_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    measTimeout |-> !sspStrobe);

  assert_window_respected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(measDelay) |-> (measDelay >= $past(filtWin)) && !measTimeout);
endmodule

bind tx_delay_comp tx_delay_comp_chk #(.CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .edgeMark   (edgeMark),
  .dataPhase  (dataPhase),
  .filtWin    (filtWin),
  .measDelay  (measDelay),
  .measTimeout(measTimeout),
  .sspStrobe  (sspStrobe),
  .bitErr     (bitErr)
);

// File: tb/tx_delay_comp_tb_top.sv
`timescale 1ns/1ps
module tx_delay_comp_tb_top;
  localparam int CW = 6;
  localparam int MAXD = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txBit = 1'b1, rxBit = 1'b1, dataPhase = 1'b0, edgeMark = 1'b0, bitStart = 1'b0;
  logic [CW-1:0] filtWin = '0, sspOffset = '0;
  logic [CW-1:0] measDelay;
  logic measTimeout, sspStrobe, bitErr;

  int checks = 0;
  int errors = 0;
  int curDelay = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tx_delay_comp #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .txBit(txBit), .rxBit(rxBit), .dataPhase(dataPhase),
    .edgeMark(edgeMark), .bitStart(bitStart), .filtWin(filtWin), .sspOffset(sspOffset),
    .measDelay(measDelay), .measTimeout(measTimeout), .sspStrobe(sspStrobe), .bitErr(bitErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      adv(); edgeMark = 1'b0; bitStart = 1'b0; dataPhase = 1'b0; rxBit = 1'b1;
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(measDelay == 0, "R1 measDelay", int'(measDelay), 0);
    check(!measTimeout && !sspStrobe && !bitErr, "R1 flags",
          int'({measTimeout, sspStrobe, bitErr}), 0);
  endtask

  // measurement with optional glitch; R2/R3/R4
  task automatic measure(input int win, input int d, input int glitch, input string tag);
    int prev = curDelay;
    filtWin = CW'(win);
    adv(); edgeMark = 1'b1; rxBit = 1'b1; dataPhase = 1'b0; bitStart = 1'b0;
    for (int j = 1; j <= d; j++) begin
      adv(); edgeMark = 1'b0;
      rxBit = (j == d || j == glitch) ? 1'b0 : 1'b1;
      @(negedge clk);
      check(int'(measDelay) == prev, "R4 old delay held", int'(measDelay), prev);
      if (j == 1) check(!measTimeout, "R5 timeout cleared", int'(measTimeout), 0);
    end
    adv(); rxBit = 1'b0;
    @(negedge clk);
    check(int'(measDelay) == d, tag, int'(measDelay), d);
    check(!measTimeout, "R5 no timeout after capture", int'(measTimeout), 0);
    adv(); rxBit = 1'b1;
    curDelay = d;
  endtask

  // data-phase run; R6/R7/R8/R9
  task automatic run_data(input int offset, input int bt, input int nBits, input int dpOff,
                          input int dpOn, input int flipAt, input bit valid, input string tag);
    bit stA[0:399];
    bit txA[0:399];
    bit rxA[0:399];
    bit dpA[0:399];
    int T = curDelay + offset;
    int n = nBits * bt + T + 4;
    int nSsp = 0;
    sspOffset = CW'(offset);
    idle(130);
    for (int t = 0; t < n; t++) begin
      int k = t / bt;
      stA[t] = (t % bt == 0) && (t < nBits * bt);
      txA[t] = (t < nBits * bt) ? (((k * 5 + 2) % 3) != 0) : 1'b1;
      dpA[t] = !(t >= dpOff && t < dpOn);
      rxA[t] = (t >= curDelay) ? txA[t - curDelay] : 1'b1;
      if (t == flipAt) rxA[t] = !rxA[t];
    end
    for (int t = 0; t < n; t++) begin
      bit eS, eE;
      adv();
      edgeMark = 1'b0; bitStart = stA[t]; txBit = txA[t]; rxBit = rxA[t]; dataPhase = dpA[t];
      eS = valid && (t >= T) && stA[t - T] && dpA[t - T] && dpA[t];
      eE = eS && (txA[t - T] != rxA[t]);
      if (eS) nSsp++;
      @(negedge clk);
      check(sspStrobe == eS, {tag, " R6 strobe"}, int'(sspStrobe), int'(eS));
      check(bitErr == eE, {tag, " R7 bit error"}, int'(bitErr), int'(eE));
    end
    if (valid) check(nSsp > 0, {tag, " R8 strobes present"}, nSsp, 1);
    idle(2);
  endtask

  // no returning edge; R5/R10
  task automatic test_timeout();
    int prev = curDelay;
    filtWin = CW'(2);
    adv(); edgeMark = 1'b1; rxBit = 1'b1; dataPhase = 1'b1; bitStart = 1'b0;
    for (int j = 1; j <= MAXD + 3; j++) begin
      adv(); edgeMark = 1'b0; bitStart = (j % 3 == 0); txBit = j[1]; rxBit = 1'b1;
      @(negedge clk);
      check(!sspStrobe, "R10 no strobe while measuring", int'(sspStrobe), 0);
      if (j == MAXD) check(!measTimeout, "R5 timeout not yet", int'(measTimeout), 0);
      if (j == MAXD + 1) check(measTimeout, "R5 timeout set", int'(measTimeout), 1);
    end
    check(int'(measDelay) == prev, "R5 delay unchanged", int'(measDelay), prev);
    dataPhase = 1'b0; bitStart = 1'b0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    measure(2, 7, -1, "R2 delay measured");
    measure(8, 12, 3, "R3 glitch before window ignored");
    run_data(4, 5, 10, 999, 999, 26, 1'b1, "inflight");
    run_data(3, 4, 12, 10, 30, -1, 1'b1, "dpgate R9");
    test_timeout();
    run_data(2, 4, 6, 999, 999, -1, 1'b0, "after timeout R5");
    measure(1, MAXD, -1, "R2 max delay");
    run_data(0, 8, 6, 999, 999, 71, 1'b1, "long delay R8");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule